// File: doc/BRIEF.md
# Configuration image byte streamer

This block loads a configuration image into a byte-wide configuration port of a programmable-logic target. After a start pulse it pulses a reset strobe to the target, waits a settle time, writes one zero lead-in byte, then reads a 16-byte header from a byte-addressable source memory. The header's first four bytes hold the payload length as a big-endian 32-bit count. The other twelve header bytes are never used.

The payload follows the header at byte offset 16. It is sent to the port in address order, one byte for each valid/ready handshake. Five zero trailer bytes follow it. The cycle after the last trailer byte is accepted, the target's error line is sampled once. When the line is high the load ends in the fail state and interrupt enable stays low. When it is low, a second settle time passes, and then done and interrupt enable rise together. The source memory returns read data one cycle after a read strobe.

Top module: `cfg_image_streamer`

## Requirements
- R1: While and after reset, busy, done, fail, irq_en, tgt_reset, mem_rd and cfg_valid are all 0.
- R2: A start pulse seen in idle raises tgt_reset in the next cycle for exactly RST_CYCLES cycles. Exactly SETTLE_CYCLES cycles with tgt_reset and cfg_valid both low then pass before cfg_valid first rises.
- R3: The first byte accepted at the port in every load is 0x00, and it comes before any header read.
- R4: The payload length L is memory bytes 0..3 read big-endian (byte 0 is the most significant). The values in bytes 4..15 have no effect on what is sent.
- R5: Exactly L payload bytes are sent, taken from addresses 16 to 16+L-1 in ascending order.
- R6: Once cfg_valid is high, it and cfg_data hold steady until a cycle with cfg_ready high.
- R7: Exactly 5 bytes of value 0x00 follow the payload. When L is 0 the stream is the lead-in byte plus those 5 bytes.
- R8: cfg_err is sampled only in the cycle after the last trailer handshake. If it is high, fail rises in the next cycle with done and irq_en low. A high cfg_err at any earlier time has no effect.
- R9: On success, done and irq_en rise together exactly POST_CYCLES+1 cycles after the sampling cycle. Both flags, and fail, hold until the next start, which clears them.
- R10: A start pulse while busy is ignored: no second reset strobe, and the stream is unchanged.
- R11: mem_rd is never high in two consecutive cycles. A load makes exactly L+4 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, acted on only in idle |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load succeeded |
| fail | output | 1 | Last load reported an error |
| irq_en | output | 1 | Interrupt enable, set with done |
| tgt_reset | output | 1 | Reset strobe to the target |
| mem_rd | output | 1 | Source memory read strobe |
| mem_addr | output | AW | Source memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| cfg_valid | output | 1 | Byte on cfg_data is offered |
| cfg_data | output | 8 | Configuration byte |
| cfg_ready | input | 1 | Target accepts the byte this cycle |
| cfg_err | input | 1 | Target error line |

## Verification
The bench uses a length of 0x102, so a header that is read little-endian or truncated to one byte sends the wrong number of bytes. It loads junk into the reserved header bytes to show they are ignored. A zero length must still produce the five trailer bytes; a design that skips straight to the check would send only the lead-in byte. Random backpressure exposes a port that drops or changes a byte before it is accepted. An error line held high only during the payload must not fail the load, which catches sampling taken at the wrong time. A second start mid-load must not restart the reset strobe. The bench also measures the reset width, the settle gap and the done latency to the cycle, which catches off-by-one errors in the delay counter.

// File: rtl/cfgs_pkg.sv
// Package: shared constants and the sequencer state type for the
// configuration image streamer. Assumes an 8-bit source memory.
package cfgs_pkg;

    localparam int HDR_LEN_BYTES = 4;   // length field size, big-endian
    localparam int PAYLOAD_OFS   = 16;  // first payload byte address
    localparam int PAD_BYTES     = 5;   // trailing zero bytes
    localparam int LEN_W         = 32;  // payload length width

    typedef enum logic [3:0] {
        S_IDLE,
        S_TRST,
        S_SETTLE,
        S_DUMMY,
        S_HDR_RD,
        S_HDR_CAP,
        S_LEN_CHK,
        S_PL_RD,
        S_PL_CAP,
        S_PL_WT,
        S_PAD_WT,
        S_CHECK,
        S_POST
    } st_t;

    // Largest of three delay limits, used to size the shared counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cfgs_delay.sv
// Module: cycle delay timer. While run is high it counts cycles and
// raises expired in the limit-th cycle. It restarts after expiry or
// when run drops, so back-to-back phases each get a full count.
// Assumes limit >= 1 whenever run is high.
module cfgs_delay #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Expiry marks the last cycle of the current phase.
    assign expired = run && (cnt == limit - 1'b1);

    // Count cycles while the phase runs, restart on expiry or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // The counter never passes the limit of the running phase.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < limit));

endmodule

// File: rtl/cfgs_len_acc.sv
// Module: header length assembler. It shifts header bytes in from the
// right, so the first byte read ends up most significant (big-endian).
// Assumes clr comes before the first shift of a header.
module cfgs_len_acc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic [7:0]   byte_in,
    output logic [W-1:0] len
);
    // Clear at start of load, then accumulate one byte per shift.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            len <= '0;
        end else if (shift) begin
            len <= {len[W-9:0], byte_in};
        end
    end

    // The newest byte lands in the low byte of the length.
    p_len_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift && !clr |=> len[7:0] == $past(byte_in));

endmodule

// File: rtl/cfgs_byte_port.sv
// Module: output register for the byte-wide configuration port. load
// places a byte and raises valid. The byte is held until the target
// accepts it with ready. A load in the same cycle as an accept chains
// the next byte with no gap.
module cfgs_byte_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       ready,
    output logic       valid,
    output logic [7:0] data,
    output logic       xfer
);
    assign xfer = valid && ready;

    // Hold the offered byte until it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= 8'h00;
        end else if (load) begin
            valid <= 1'b1;
            data  <= load_data;
        end else if (xfer) begin
            valid <= 1'b0;
        end
    end

    // An offered byte stays unchanged until it is accepted.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(data));

    // A new byte never overwrites one that is still waiting.
    p_no_clobber_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!valid || ready));

endmodule

// File: rtl/cfg_image_streamer.sv
// Module: configuration image streamer top. It sequences reset strobe,
// settle wait, lead-in byte, header read, payload stream, trailer bytes,
// error check and post-settle wait. Assumes the source memory returns
// data one cycle after mem_rd, and AW >= 5 so the payload offset fits.
module cfg_image_streamer
    import cfgs_pkg::*;
#(
    parameter int AW            = 16,
    parameter int RST_CYCLES    = 4,
    parameter int SETTLE_CYCLES = 8,
    parameter int POST_CYCLES   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic          irq_en,
    output logic          tgt_reset,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic          cfg_valid,
    output logic [7:0]    cfg_data,
    input  logic          cfg_ready,
    input  logic          cfg_err
);
    localparam int MAXD = max3(RST_CYCLES, SETTLE_CYCLES, POST_CYCLES);
    localparam int CW   = $clog2(MAXD + 1);
    localparam int HW   = $clog2(HDR_LEN_BYTES);
    localparam int PW   = $clog2(PAD_BYTES);

    st_t              st, nxt;
    logic [HW-1:0]    hidx;
    logic [LEN_W-1:0] pidx;
    logic [PW-1:0]    pad_cnt;
    logic [LEN_W-1:0] len;
    logic             done_q, fail_q, irq_q;

    logic             tmr_run, tmr_exp;
    logic [CW-1:0]    tmr_lim;
    logic             port_load, xfer;
    logic             len_clr, len_shift;

    // Shared cycle timer for the three wait phases.
    cfgs_delay #(.CW(CW)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .limit   (tmr_lim),
        .expired (tmr_exp)
    );

    // Big-endian length assembled from the first header bytes.
    cfgs_len_acc #(.W(LEN_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (len_clr),
        .shift   (len_shift),
        .byte_in (mem_rdata),
        .len     (len)
    );

    // Port register; payload bytes come from memory, the rest are zero.
    cfgs_byte_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (port_load),
        .load_data ((st == S_PL_CAP) ? mem_rdata : 8'h00),
        .ready     (cfg_ready),
        .valid     (cfg_valid),
        .data      (cfg_data),
        .xfer      (xfer)
    );

    // Next-state and per-state control strobes.
    always_comb begin
        nxt       = st;
        port_load = 1'b0;
        mem_rd    = 1'b0;
        len_clr   = 1'b0;
        len_shift = 1'b0;
        tmr_run   = 1'b0;
        tmr_lim   = CW'(1);
        unique case (st)
            S_IDLE: begin
                if (start) begin
                    len_clr = 1'b1;
                    nxt     = S_TRST;
                end
            end
            S_TRST: begin
                tmr_run = 1'b1;
                tmr_lim = CW'(RST_CYCLES);
                if (tmr_exp) nxt = S_SETTLE;
            end
            S_SETTLE: begin
                tmr_run = 1'b1;
                tmr_lim = CW'(SETTLE_CYCLES);
                if (tmr_exp) begin
                    port_load = 1'b1;
                    nxt       = S_DUMMY;
                end
            end
            S_DUMMY: begin
                if (xfer) nxt = S_HDR_RD;
            end
            S_HDR_RD: begin
                mem_rd = 1'b1;
                nxt    = S_HDR_CAP;
            end
            S_HDR_CAP: begin
                len_shift = 1'b1;
                nxt = (hidx == HW'(HDR_LEN_BYTES - 1)) ? S_LEN_CHK : S_HDR_RD;
            end
            S_LEN_CHK: begin
                if (len == '0) begin
                    port_load = 1'b1;
                    nxt       = S_PAD_WT;
                end else begin
                    nxt = S_PL_RD;
                end
            end
            S_PL_RD: begin
                mem_rd = 1'b1;
                nxt    = S_PL_CAP;
            end
            S_PL_CAP: begin
                port_load = 1'b1;
                nxt       = S_PL_WT;
            end
            S_PL_WT: begin
                if (xfer) begin
                    if (pidx == len - 1'b1) begin
                        port_load = 1'b1;
                        nxt       = S_PAD_WT;
                    end else begin
                        nxt = S_PL_RD;
                    end
                end
            end
            S_PAD_WT: begin
                if (xfer) begin
                    if (pad_cnt == PW'(PAD_BYTES - 1)) begin
                        nxt = S_CHECK;
                    end else begin
                        port_load = 1'b1;
                    end
                end
            end
            S_CHECK: begin
                nxt = cfg_err ? S_IDLE : S_POST;
            end
            S_POST: begin
                tmr_run = 1'b1;
                tmr_lim = CW'(POST_CYCLES);
                if (tmr_exp) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // Header, payload and trailer byte indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hidx    <= '0;
            pidx    <= '0;
            pad_cnt <= '0;
        end else begin
            if (st == S_IDLE)    hidx <= '0;
            if (st == S_HDR_CAP) hidx <= hidx + 1'b1;
            if (st == S_LEN_CHK) pidx <= '0;
            if (st == S_PL_WT && xfer) pidx <= pidx + 1'b1;
            if (nxt == S_PAD_WT && st != S_PAD_WT) pad_cnt <= '0;
            else if (st == S_PAD_WT && xfer)       pad_cnt <= pad_cnt + 1'b1;
        end
    end

    // Result flags: cleared by a start, set at the end of a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            irq_q  <= 1'b0;
        end else if (st == S_IDLE && start) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            irq_q  <= 1'b0;
        end else if (st == S_CHECK && cfg_err) begin
            fail_q <= 1'b1;
        end else if (st == S_POST && tmr_exp) begin
            done_q <= 1'b1;
            irq_q  <= 1'b1;
        end
    end

    // Read address: header bytes from 0, payload from the fixed offset.
    always_comb begin
        if (st == S_PL_RD) mem_addr = pidx[AW-1:0] + AW'(PAYLOAD_OFS);
        else               mem_addr = AW'(hidx);
    end

    assign busy      = (st != S_IDLE);
    assign tgt_reset = (st == S_TRST);
    assign done      = done_q;
    assign fail      = fail_q;
    assign irq_en    = irq_q;

    // One read outstanding at a time.
    p_rd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // Nothing is read or offered while the target is held in reset.
    p_quiet_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_reset |-> !cfg_valid && !mem_rd);

    // Success and failure never coexist.
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fail);

    // Interrupt enable only accompanies a successful load.
    p_irq_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en |-> done);

    // Result flags stay put while idle without a start.
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(done) && $stable(fail));

    // A start pulse seen while busy does not restart the reset strobe.
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !tgt_reset |=> !$rose(tgt_reset));

endmodule

// File: tb/cfg_image_streamer_test.sv
module cfg_image_streamer_test;
    localparam int AW    = 10;
    localparam int RSTC  = 3;
    localparam int SETC  = 5;
    localparam int POSTC = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          busy, done, fail, irq_en, tgt_reset, mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic          cfg_valid;
    logic [7:0]    cfg_data;
    logic          cfg_ready;
    logic          cfg_err;

    always #5 clk = ~clk;

    cfg_image_streamer #(
        .AW(AW), .RST_CYCLES(RSTC), .SETTLE_CYCLES(SETC), .POST_CYCLES(POSTC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .fail(fail), .irq_en(irq_en), .tgt_reset(tgt_reset), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .cfg_valid(cfg_valid),
        .cfg_data(cfg_data), .cfg_ready(cfg_ready), .cfg_err(cfg_err)
    );

    // Source memory model with one cycle of read latency.
    logic [7:0] mem [0:1023];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Port and timing monitor, sampled on the falling edge.
    int cyc, ncap, rst_hi, gap, nreads, last_x, done_c, fail_c, hold_err, rst_rise;
    bit seen_v, pv, pr, prst;
    logic [7:0] pd;
    logic [7:0] cap [0:1023];

    always @(negedge clk) begin
        cyc++;
        if (tgt_reset) rst_hi++;
        if (tgt_reset && !prst) rst_rise++;
        if (!tgt_reset && rst_hi > 0 && !seen_v && !cfg_valid) gap++;
        if (cfg_valid) seen_v = 1'b1;
        if (pv && !pr && (!cfg_valid || cfg_data != pd)) hold_err++;
        if (cfg_valid && cfg_ready) begin
            if (ncap < 1024) cap[ncap] = cfg_data;
            ncap++;
            last_x = cyc;
        end
        if (mem_rd) nreads++;
        if (done && done_c < 0) done_c = cyc;
        if (fail && fail_c < 0) fail_c = cyc;
        pv = cfg_valid; pr = cfg_ready; pd = cfg_data; prst = tgt_reset;
    end

    task automatic clear_mon();
        ncap = 0; rst_hi = 0; gap = 0; nreads = 0; last_x = 0;
        done_c = -1; fail_c = -1; hold_err = 0; rst_rise = 0; seen_v = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * seed + 3) & 255);
    endfunction

    task automatic load_image(input int len, input int seed, input bit resv);
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        mem[0] = 8'(len >> 24); mem[1] = 8'(len >> 16);
        mem[2] = 8'(len >> 8);  mem[3] = 8'(len);
        for (int i = 4; i < 16; i++) mem[i] = resv ? 8'(i * 29 + 77) : 8'h00;
        for (int i = 0; i < len; i++) mem[16 + i] = pat(i, seed);
    endtask

    task automatic run_load(input int rdy_mode, input int err_mode, input int restart_at);
        int n;
        logic [15:0] lf;
        n = 0;
        lf = 16'hACE1;
        clear_mon();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        while (1) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cfg_ready = (rdy_mode == 0) ? 1'b1 : lf[0];
            cfg_err   = (err_mode == 1) || (err_mode == 2 && n < 40);
            start     = (n == restart_at);
            @(posedge clk); #1;
            n++;
            if (!busy) break;
            if (n > 20000) begin
                chk(1'b0, "watchdog", n, 0);
                break;
            end
        end
        start = 1'b0; cfg_err = 1'b0; cfg_ready = 1'b1;
        @(posedge clk); #1;
    endtask

    // Lead-in, payload and trailer as seen at the port, plus read count.
    task automatic check_stream(input int len, input int seed, input string tag);
        int bad;
        bad = 0;
        chk(ncap == len + 6, {tag, " R5 R7 byte count"}, ncap, len + 6);
        chk(cap[0] == 8'h00, {tag, " R3 lead-in byte"}, cap[0], 0);
        for (int i = 0; i < len; i++) if (cap[1 + i] != pat(i, seed)) bad++;
        chk(bad == 0, {tag, " R5 payload order"}, bad, 0);
        bad = 0;
        for (int i = 0; i < 5; i++) if (cap[len + 1 + i] != 8'h00) bad++;
        chk(bad == 0, {tag, " R7 trailer zeros"}, bad, 0);
        chk(nreads == len + 4, {tag, " R11 read count"}, nreads, len + 4);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; cfg_ready = 1'b1; cfg_err = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && !fail && !irq_en, "R1 flags in reset", {busy, done, fail, irq_en}, 0);
        chk(!tgt_reset && !mem_rd && !cfg_valid, "R1 strobes in reset", {tgt_reset, mem_rd, cfg_valid}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!busy && !cfg_valid && !done, "R1 idle after reset", {busy, cfg_valid, done}, 0);
    endtask

    task automatic t_basic();
        load_image(6, 7, 1'b0);
        run_load(0, 0, -1);
        chk(rst_hi == RSTC, "R2 reset width", rst_hi, RSTC);
        chk(gap == SETC, "R2 settle gap", gap, SETC);
        check_stream(6, 7, "basic");
        chk(done && irq_en && !fail, "R9 success flags", {done, irq_en, fail}, 6);
        chk(done_c - last_x == POSTC + 2, "R9 done latency", done_c - last_x, POSTC + 2);
        repeat (10) @(posedge clk);
        #1;
        chk(done && irq_en, "R9 flags hold in idle", {done, irq_en}, 3);
    endtask

    task automatic t_backpressure();
        load_image(11, 13, 1'b1);
        run_load(1, 0, -1);
        chk(hold_err == 0, "R6 hold under backpressure", hold_err, 0);
        check_stream(11, 13, "backpressure");
        chk(done && !fail, "R9 done after backpressure", {done, fail}, 2);
    endtask

    task automatic t_zero_len();
        load_image(0, 1, 1'b1);
        run_load(0, 0, -1);
        check_stream(0, 1, "zero-length R7");
        chk(done, "R7 zero length completes", done, 1);
    endtask

    task automatic t_big_endian();
        load_image(258, 5, 1'b1);
        run_load(0, 0, -1);
        chk(ncap == 264, "R4 length 0x102 big-endian", ncap, 264);
        check_stream(258, 5, "R4 reserved ignored");
    endtask

    task automatic t_error();
        load_image(4, 9, 1'b0);
        run_load(0, 1, -1);
        check_stream(4, 9, "error");
        chk(fail && !done && !irq_en, "R8 fail flags", {fail, done, irq_en}, 4);
        chk(fail_c - last_x == 2, "R8 fail latency", fail_c - last_x, 2);
    endtask

    task automatic t_error_early();
        load_image(12, 11, 1'b0);
        run_load(0, 2, -1);
        check_stream(12, 11, "early-error");
        chk(done && !fail, "R8 early error ignored", {done, fail}, 2);
        chk(!fail, "R9 start cleared prior fail", fail, 0);
    endtask

    task automatic t_restart();
        load_image(10, 3, 1'b0);
        run_load(0, 0, 15);
        chk(rst_rise == 1, "R10 single reset strobe", rst_rise, 1);
        check_stream(10, 3, "R10 restart");
        chk(done, "R10 load completes", done, 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_backpressure();
        t_zero_len();
        t_big_endian();
        t_error();
        t_error_early();
        t_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1500000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule